// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is a single output cell of a sum-of-products programmable logic device. It receives the OR-ed sum term for its pin, a separate product term that enables the pin driver, a shared asynchronous clear term and a shared preset term. Two global clocks are routed to every cell, and the cell picks one of them for its flip-flop.

A four-bit static configuration word sets the cell's behaviour:

- **Polarity:** whether the pin drives the true or the inverted value.
- **Output source:** whether the pin is driven by the flip-flop or directly by the sum term.
- **Clock:** which of the two global clocks drives the flip-flop.
- **Feedback:** whether the feedback line to the array carries the pin level or the internal register.

The flip-flop keeps loading on its selected clock even when the pin is combinational. This lets a buried register feed the array while the pin carries unrelated combinational logic.

The pin is modelled as three signals: a driven value, a driver enable, and the level seen on the pin from outside when the driver is off. A power-up reset clears the register. It is asserted asynchronously and released in step with the selected clock.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst_n` is low, the register holds 0. The pin therefore shows 0 when `cfg[0]`=1 (true polarity) and 1 when `cfg[0]`=0, in registered mode (`cfg[1]`=1).
- R2: With `cfg[1]`=1, `pad_out` shows the register, which loads `sum_term` on each rising edge of the selected clock.
- R3: `cfg[2]`=0 selects `clk_a` and `cfg[2]`=1 selects `clk_b`. A rising edge on the clock that is not selected leaves the register unchanged.
- R4: With `cfg[1]`=0, `pad_out` follows `sum_term` combinationally, without any clock edge.
- R5: `cfg[0]`=1 drives the pin with the non-inverted value and `cfg[0]`=0 with the inverted value, in both output modes.
- R6: A high `areset_term` clears the register at once, without a clock, and holds it at 0 while it stays high.
- R7: When `areset_term` and `preset_term` are both high on a selected clock edge, the register ends at 0.
- R8: `preset_term` sets the register to 1 only on a rising edge of the selected clock, overriding `sum_term`; it has no effect between edges.
- R9: `pad_oe` equals `oe_term` in every configuration.
- R10: With `cfg[3]`=0, `fb_out` equals `pad_out` while `oe_term` is high, and equals `pad_in` while it is low.
- R11: With `cfg[3]`=1, `fb_out` equals the register (true polarity) in both output modes. In combinational mode the register keeps loading on the selected clock.
- R12: After `rst_n` rises, the register ignores the first SYNC_STAGES (default 2) selected clock edges and loads on the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First global clock |
| clk_b | input | 1 | Second global clock |
| rst_n | input | 1 | Power-up reset, active low |
| cfg | input | 4 | Static configuration: [0] true polarity, [1] registered, [2] use clk_b, [3] register feedback |
| sum_term | input | 1 | Sum term from the array |
| oe_term | input | 1 | Output-enable product term |
| areset_term | input | 1 | Shared asynchronous clear term |
| preset_term | input | 1 | Shared synchronous preset term |
| pad_in | input | 1 | Level seen on the pin when the driver is off |
| pad_out | output | 1 | Value driven onto the pin |
| pad_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback line to the array |

## Verification
The clear term and the preset term can both be active at the same edge of the selected clock. The bench provokes this by raising both terms, with the sum term low, before a selected edge in all sixteen configurations. It judges the result by the pin and the register feedback, which must show a cleared register afterwards.

A second collision is an edge on the clock that is not selected, arriving while new data waits on the sum term. In that case the outputs must keep the previously loaded value.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  typedef struct packed {
    logic fb_reg;      // bit 3: feedback from register
    logic clk_b_sel;   // bit 2: clock from clk_b
    logic registered;  // bit 1: pin driven by register
    logic pol_high;    // bit 0: true polarity
  } mc_cfg_t;

  localparam int unsigned CFG_W = $bits(mc_cfg_t);
endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
  parameter int unsigned NUM_CLK = 2,
  localparam int unsigned SEL_W = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic [NUM_CLK-1:0] clk_in,
  input  logic [SEL_W-1:0]   sel,
  output logic               clk_out
);
  // Static select: callers change sel only while all clocks are low.
  always_comb begin
    clk_out = 1'b0;
    for (int i = 0; i < NUM_CLK; i++) begin
      if (sel == SEL_W'(i)) clk_out = clk_in[i];
    end
  end
endmodule

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg (
  input  logic clk,
  input  logic clr,
  input  logic load_en,
  input  logic sum_in,
  input  logic preset_in,
  output logic q
);
  logic q_nxt;

  // Preset wins over data; clear (async) wins over both.
  always_comb begin
    q_nxt = q;
    if (load_en) q_nxt = preset_in ? 1'b1 : sum_in;
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) q <= 1'b0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/mc_out_path.sv
module mc_out_path
  import pld_mc_pkg::*;
(
  input  mc_cfg_t cfg,
  input  logic    q,
  input  logic    sum_in,
  input  logic    oe_in,
  input  logic    pad_in,
  output logic    pad_out,
  output logic    pad_oe,
  output logic    fb_out
);
  logic data_sel;
  logic pin_level;

  always_comb begin
    data_sel  = cfg.registered ? q : sum_in;
    pad_out   = cfg.pol_high ? data_sel : ~data_sel;
    pad_oe    = oe_in;
    pin_level = oe_in ? pad_out : pad_in;
    fb_out    = cfg.fb_reg ? q : pin_level;
  end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic             sum_term,
  input  logic             oe_term,
  input  logic             areset_term,
  input  logic             preset_term,
  input  logic             pad_in,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             fb_out
);
  mc_cfg_t cfg_s;
  logic    reg_clk;
  logic    rst_sync_n;
  logic    clr;
  logic    q_r;

  assign cfg_s = mc_cfg_t'(cfg);

  mc_clk_sel #(.NUM_CLK(2)) u_clk_sel (
    .clk_in  ({clk_b, clk_a}),
    .sel     (cfg_s.clk_b_sel),
    .clk_out (reg_clk)
  );

  mc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (reg_clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign clr = ~rst_sync_n | areset_term;

  mc_state_reg u_state (
    .clk       (reg_clk),
    .clr       (clr),
    .load_en   (1'b1),
    .sum_in    (sum_term),
    .preset_in (preset_term),
    .q         (q_r)
  );

  mc_out_path u_out (
    .cfg     (cfg_s),
    .q       (q_r),
    .sum_in  (sum_term),
    .oe_in   (oe_term),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .fb_out  (fb_out)
  );
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk (
  input logic       reg_clk,
  input logic       rst_n,
  input logic       rst_sync_n,
  input logic [3:0] cfg,
  input logic       sum_term,
  input logic       oe_term,
  input logic       areset_term,
  input logic       preset_term,
  input logic       q_r,
  input logic       pad_out,
  input logic       pad_oe,
  input logic       fb_out
);
  // R1: register stays clear while the synchronised reset is active
  a_r1_reset_clear: assert property (@(posedge reg_clk)
    (!rst_n || !rst_sync_n) |-> (q_r == 1'b0));

  // R2: plain load of the sum term
  a_r2_load: assert property (@(posedge reg_clk) disable iff (!rst_n)
    (rst_sync_n && !areset_term && !preset_term) |=>
      ((q_r == $past(sum_term)) || areset_term));

  // R6: clear term keeps register at zero
  a_r6_clear_holds: assert property (@(posedge reg_clk) disable iff (!rst_n)
    areset_term |-> (q_r == 1'b0));

  // R8: preset sets the register on the edge
  a_r8_preset_sets: assert property (@(posedge reg_clk) disable iff (!rst_n)
    (rst_sync_n && preset_term && !areset_term) |=> (q_r || areset_term));

  // R5: registered pin polarity
  a_r5_polarity: assert property (@(posedge reg_clk) disable iff (!rst_n)
    cfg[1] |-> (pad_out == (cfg[0] ? q_r : ~q_r)));

  // R11: register feedback
  a_r11_fb_reg: assert property (@(posedge reg_clk) disable iff (!rst_n)
    cfg[3] |-> (fb_out == q_r));

  // R9: enable path
  a_r9_oe: assert property (@(posedge reg_clk) disable iff (!rst_n)
    pad_oe == oe_term);
endmodule

bind pld_macrocell pld_macrocell_chk u_chk (
  .reg_clk     (reg_clk),
  .rst_n       (rst_n),
  .rst_sync_n  (rst_sync_n),
  .cfg         (cfg),
  .sum_term    (sum_term),
  .oe_term     (oe_term),
  .areset_term (areset_term),
  .preset_term (preset_term),
  .q_r         (q_r),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .fb_out      (fb_out)
);

// File: tb/pld_macrocell_test.sv
module pld_macrocell_test;
  localparam int unsigned SYNC = 2;
  localparam int unsigned HALF = 4;  // 8 ns period, 125 MHz

  logic       clk_a, clk_b, rst_n;
  logic [3:0] cfg;
  logic       sum_term, oe_term, areset_term, preset_term, pad_in;
  logic       pad_out, pad_oe, fb_out;

  pld_macrocell #(.SYNC_STAGES(SYNC)) uut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .cfg(cfg),
    .sum_term(sum_term), .oe_term(oe_term), .areset_term(areset_term),
    .preset_term(preset_term), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
  );

  typedef struct {
    logic [2:0] v;
    string      tag;
  } exp_t;

  exp_t   sb[$];
  event   chk_ev;
  int     n_run  = 0;
  int     n_fail = 0;
  bit     done   = 0;
  logic   mq;
  int     msync;

  // Monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_run++;
        if ({pad_out, pad_oe, fb_out} !== e.v) begin
          n_fail++;
          $display("FAIL %s: {pad_out,pad_oe,fb_out} actual=%b expected=%b cfg=%b",
                   e.tag, {pad_out, pad_oe, fb_out}, e.v, cfg);
        end
      end
    end
  end

  function automatic logic [2:0] model_out();
    logic data, pad, fb;
    data = cfg[1] ? mq : sum_term;
    pad  = cfg[0] ? data : ~data;
    fb   = cfg[3] ? mq : (oe_term ? pad : pad_in);
    return {pad, oe_term, fb};
  endfunction

  // Driver: ck 0 = no edge, 1 = clk_a edge, 2 = clk_b edge
  task automatic drive(input logic [3:0] c, input logic s, input logic oe,
                       input logic ar, input logic pr, input logic pin,
                       input logic [1:0] ck, input string tag);
    exp_t e;
    cfg = c; sum_term = s; oe_term = oe;
    areset_term = ar; preset_term = pr; pad_in = pin;
    #1;
    if (!rst_n) begin mq = 1'b0; msync = 0; end
    if (ar) mq = 1'b0;
    if (ck == 2'd1) clk_a = 1'b1;
    if (ck == 2'd2) clk_b = 1'b1;
    if ((ck == 2'd1 && !c[2]) || (ck == 2'd2 && c[2])) begin
      if (rst_n) begin
        if (msync < SYNC) msync++;
        else if (ar)      mq = 1'b0;
        else              mq = pr ? 1'b1 : s;
      end
    end
    #2;
    e.v = model_out(); e.tag = tag;
    sb.push_back(e);
    ->chk_ev;
    #(HALF - 2);
    clk_a = 1'b0; clk_b = 1'b0;
    #(HALF - 1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    clk_a = 0; clk_b = 0; rst_n = 0; cfg = 4'b0011;
    sum_term = 0; oe_term = 1; areset_term = 0; preset_term = 0; pad_in = 0;
    mq = 0; msync = 0;
    #10;
    // R1: reset state, both polarities, with clock edges during reset
    drive(4'b0011, 1, 1, 0, 0, 0, 2'd1, "R1 true pol");
    drive(4'b0010, 1, 1, 0, 0, 0, 2'd1, "R1 inv pol");
    drive(4'b1011, 1, 1, 0, 0, 0, 2'd1, "R1 reg fb");
    rst_n = 1;
    // R12: two ignored edges, then load
    drive(4'b0011, 1, 1, 0, 0, 0, 2'd1, "R12 edge1");
    drive(4'b0011, 1, 1, 0, 0, 0, 2'd1, "R12 edge2");
    drive(4'b0011, 1, 1, 0, 0, 0, 2'd1, "R12 edge3 load");
    for (int c = 0; c < 16; c++) begin
      logic [3:0] cv;
      logic [1:0] sel, oth;
      cv  = 4'(c);
      sel = cv[2] ? 2'd2 : 2'd1;
      oth = cv[2] ? 2'd1 : 2'd2;
      drive(cv, 1, 1, 1, 0, 0, 2'd0, "R6 async clear");
      drive(cv, 1, 1, 1, 0, 0, sel,  "R6 clear held");
      drive(cv, 1, 1, 0, 0, 0, sel,  "R2/R11 load one");
      drive(cv, 0, 1, 0, 0, 0, oth,  "R3 other clock");
      drive(cv, 1, 1, 0, 0, 0, 2'd0, "R4/R5 comb path");
      drive(cv, 0, 1, 0, 0, 0, sel,  "R2/R5 load zero");
      drive(cv, 0, 1, 0, 1, 0, 2'd0, "R8 preset no edge");
      drive(cv, 0, 1, 0, 1, 0, sel,  "R8 preset edge");
      drive(cv, 0, 1, 1, 1, 0, sel,  "R7 clear over preset");
      drive(cv, 1, 0, 0, 0, 1, 2'd0, "R9/R10 pin high");
      drive(cv, 1, 0, 0, 0, 0, 2'd0, "R9/R10 pin low");
      drive(cv, 1, 1, 0, 0, 1, 2'd0, "R10 driven");
    end
    #10;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule